// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block schedules the conversions of a 16-input, 10-bit multiplexed analog-to-digital converter. Software writes a mode, a channel number, a wait-enable bit and a start pulse. The sequencer then asks an external conversion engine for one conversion at a time. It does this through a start/done handshake, and it files each returned sample into a result register that carries the channel number beside the data. The engine itself (sampling and successive approximation) is outside the block.

There are four modes: one channel once, one channel repeatedly, a downward scan once, and the same scan repeated. A scan begins at the chosen channel and counts down to channel 0. In the repeated scan it then returns to the chosen channel.

Results that nobody has collected are handled in one of two ways:
- They are overwritten and an overrun interrupt is raised.
- With wait-enable set, they are parked in a one-entry holding buffer and sequencing pauses until a read.

While a continuous mode runs, one extra channel can be injected between scheduled conversions. Its result goes to a separate register, and the running mode carries on afterwards.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `cfg_mode[1]` selects scanning (1) or a single channel (0), and `cfg_mode[0]` selects continuous (1) or once (0). A one-cycle `cfg_start` while `busy` is low begins a sequence. `cfg_start` is ignored while `busy` is high.
- R2: In single-once mode exactly one conversion of `cfg_chan` is requested. Its data and channel appear in `res_data`/`res_chan` with `res_valid` set, and `busy` falls on the clock edge that accepts the result.
- R3: Scan modes request the channels from the chosen channel down to 0. Scan-once stops after channel 0, and scan-continuous then restarts at the chosen channel.
- R4: Single-continuous mode requests the same channel over and over.
- R5: With `cfg_wait_en` low, a result that arrives while `res_valid` is high (and no read occurs in that cycle) overwrites the register. `irq_ovr` is then high for one cycle, starting on that same edge.
- R6: With `cfg_wait_en` high, such a result goes to a holding buffer and no further `eng_start` is issued. A `res_rd` moves the held value into the result register and sequencing resumes.
- R7: A `res_rd` pulse with nothing held clears `res_valid`.
- R8: An `inj_req` accepted during a continuous mode is converted at the next conversion boundary, ahead of the next scheduled channel. Its data and channel go to `inj_res_data`/`inj_res_chan` with a one-cycle `inj_res_upd`, never to the main result register. The scheduled order then continues unchanged.
- R9: `inj_req` has no effect when the block is idle or running a once mode.
- R10: Clearing `cfg_mode[0]` ends a single-channel sequence after the conversion in progress, and ends a scan after channel 0 of the current pass.
- R11: During and right after reset, `busy`, `res_valid`, `irq_ovr`, `inj_res_upd` and `eng_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Bit 1 scan, bit 0 continuous |
| cfg_chan | input | 4 | Channel, or top channel of a scan |
| cfg_start | input | 1 | Start pulse |
| cfg_wait_en | input | 1 | Hold on unread result instead of overrun |
| busy | output | 1 | Sequence active |
| res_rd | input | 1 | Result register read strobe |
| res_data | output | 10 | Latest normal result |
| res_chan | output | 4 | Channel of latest normal result |
| res_valid | output | 1 | Result unread |
| irq_ovr | output | 1 | Overrun interrupt pulse |
| inj_req | input | 1 | Injection request pulse |
| inj_chan | input | 4 | Channel to inject |
| inj_res_data | output | 10 | Injected conversion result |
| inj_res_chan | output | 4 | Channel of injected result |
| inj_res_upd | output | 1 | Pulse when injection result written |
| eng_start | output | 1 | Conversion request to engine |
| eng_chan | output | 4 | Channel for requested conversion |
| eng_done | input | 1 | Engine conversion complete |
| eng_data | input | 10 | Engine result |

## Verification
The assertions rely on three properties of the inputs:
- The engine raises `eng_done` only once per `eng_start`, and only after it.
- `res_rd` is a single-cycle pulse.
- `inj_req` does not arrive in the very cycle a pending injection is launched.

The bench's engine model answers each start exactly once after a fixed latency. Its reader issues one-cycle read pulses and never re-reads until it has seen `res_valid` again. Injection requests are placed while a conversion is in flight, which is well clear of any launch cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NEXT = 2'd1,
    ST_CONV = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_sched.sv
module adc_seq_sched #(
  parameter int NUM_CH = 16,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_ch,
  input  logic          load_scan,
  input  logic          adv,
  output logic [CW-1:0] cur_ch,
  output logic          scan,
  output logic          wrap_now,
  output logic          pass_end
);
  logic [CW-1:0] start_q, start_d, cur_q, cur_d, step_ch;
  logic          scan_q, scan_d, pend_q, pend_d;

  always_comb begin
    wrap_now = !scan_q || (cur_q == '0);
    if (!scan_q)           step_ch = cur_q;
    else if (cur_q == '0)  step_ch = start_q;
    else                   step_ch = cur_q - 1'b1;
  end

  always_comb begin
    start_d = start_q;
    cur_d   = cur_q;
    scan_d  = scan_q;
    pend_d  = pend_q;
    if (load) begin
      start_d = load_ch;
      cur_d   = load_ch;
      scan_d  = load_scan;
      pend_d  = 1'b0;
    end else if (adv) begin
      cur_d  = step_ch;
      pend_d = wrap_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
      scan_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else if (load || adv) begin
      start_q <= start_d;
      cur_q   <= cur_d;
      scan_q  <= scan_d;
      pend_q  <= pend_d;
    end
  end

  assign cur_ch   = cur_q;
  assign scan     = scan_q;
  assign pass_end = pend_q;

  // R3: a scan never leaves the window [0, start]
  a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    scan_q |-> (cur_q <= start_q));

  // R3: a mid-pass step goes down by exactly one
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && scan_q && cur_q != '0) |=> (cur_q == $past(cur_q) - 1'b1));
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int NUM_CH = 16,
  parameter int DW     = 10,
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] wr_chan,
  input  logic          rd_en,
  input  logic          wait_en,
  output logic          park,
  output logic          parked,
  output logic [DW-1:0] res_data,
  output logic [CW-1:0] res_chan,
  output logic          res_valid,
  output logic          ovr_irq
);
  logic [DW-1:0] data_q, data_d, hold_data_q;
  logic [CW-1:0] chan_q, chan_d, hold_chan_q;
  logic          valid_q, valid_d, full_q, full_d, irq_q, irq_d;
  logic          collide, load_new, load_hold, res_en;

  always_comb begin
    collide   = wr_en && valid_q && !rd_en;
    park      = collide && wait_en;
    irq_d     = collide && !wait_en;
    load_new  = wr_en && !park;
    load_hold = rd_en && full_q && !wr_en;
    res_en    = load_new || load_hold;
    data_d    = load_new ? wr_data : hold_data_q;
    chan_d    = load_new ? wr_chan : hold_chan_q;
    if (res_en)      valid_d = 1'b1;
    else if (rd_en)  valid_d = 1'b0;
    else             valid_d = valid_q;
    if (park)        full_d = 1'b1;
    else if (rd_en)  full_d = 1'b0;
    else             full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      full_q  <= full_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      chan_q <= '0;
    end else if (res_en) begin
      data_q <= data_d;
      chan_q <= chan_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data_q <= '0;
      hold_chan_q <= '0;
    end else if (park) begin
      hold_data_q <= wr_data;
      hold_chan_q <= wr_chan;
    end
  end

  assign parked    = full_q;
  assign res_data  = data_q;
  assign res_chan  = chan_q;
  assign res_valid = valid_q;
  assign ovr_irq   = irq_q;

  // R6: a held entry implies the visible register is still unread
  a_r6_hold_behind_valid: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> valid_q);

  // R6: nothing is written while an entry is held
  a_r6_no_write_parked: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !wr_en);

  // R5: an overrun pulse only follows an unread register
  a_r5_ovr_on_unread: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(valid_q));
endmodule

// File: rtl/adc_seq_inj.sv
module adc_seq_inj #(
  parameter int NUM_CH = 16,
  parameter int DW     = 10,
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CW-1:0] req_ch,
  input  logic          accept_en,
  input  logic          take,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  output logic          pend,
  output logic [CW-1:0] pend_ch,
  output logic [DW-1:0] res_data,
  output logic [CW-1:0] res_chan,
  output logic          upd
);
  logic          pend_q, pend_d, set, upd_q;
  logic [CW-1:0] pch_q, pch_d, fly_q, rch_q;
  logic [DW-1:0] rdat_q;

  always_comb begin
    set    = req && accept_en && !pend_q;
    pend_d = set || (pend_q && !take && !clr);
    pch_d  = set ? req_ch : pch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pch_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pch_q  <= pch_d;
      upd_q  <= wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fly_q <= '0;
    else if (take) fly_q <= pch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
      rch_q  <= '0;
    end else if (wr) begin
      rdat_q <= wr_data;
      rch_q  <= fly_q;
    end
  end

  assign pend     = pend_q;
  assign pend_ch  = pch_q;
  assign res_data = rdat_q;
  assign res_chan = rch_q;
  assign upd      = upd_q;

  // R8: a launch only ever consumes a pending request
  a_r8_take_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_q);

  // R9: an idle sequencer holds no request
  a_r9_idle_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 10,
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_chan,
  input  logic          cfg_start,
  input  logic          cfg_wait_en,
  output logic          busy,
  input  logic          res_rd,
  output logic [DW-1:0] res_data,
  output logic [CW-1:0] res_chan,
  output logic          res_valid,
  output logic          irq_ovr,
  input  logic          inj_req,
  input  logic [CW-1:0] inj_chan,
  output logic [DW-1:0] inj_res_data,
  output logic [CW-1:0] inj_res_chan,
  output logic          inj_res_upd,
  output logic          eng_start,
  output logic [CW-1:0] eng_chan,
  input  logic          eng_done,
  input  logic [DW-1:0] eng_data
);
  seq_state_e    st_q, st_d;
  logic          more_q, more_d, fly_q, fly_d;
  logic          sched_load, sched_adv, res_wr, inj_take, inj_wr;
  logic          cont_live, idle;
  logic [CW-1:0] cur_ch, pend_ch;
  logic          scan, wrap_now, pass_end, res_park, res_parked, inj_pend;

  assign cont_live = cfg_mode[0];
  assign idle      = (st_q == ST_IDLE);

  adc_seq_sched #(.NUM_CH(NUM_CH)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .load(sched_load), .load_ch(cfg_chan), .load_scan(cfg_mode[1]),
    .adv(sched_adv),
    .cur_ch(cur_ch), .scan(scan), .wrap_now(wrap_now), .pass_end(pass_end)
  );

  adc_seq_result #(.NUM_CH(NUM_CH), .DW(DW)) u_result (
    .clk(clk), .rst_n(rst_n),
    .wr_en(res_wr), .wr_data(eng_data), .wr_chan(cur_ch),
    .rd_en(res_rd), .wait_en(cfg_wait_en),
    .park(res_park), .parked(res_parked),
    .res_data(res_data), .res_chan(res_chan), .res_valid(res_valid),
    .ovr_irq(irq_ovr)
  );

  adc_seq_inj #(.NUM_CH(NUM_CH), .DW(DW)) u_inj (
    .clk(clk), .rst_n(rst_n),
    .req(inj_req), .req_ch(inj_chan),
    .accept_en(!idle && cont_live),
    .take(inj_take), .clr(idle),
    .wr(inj_wr), .wr_data(eng_data),
    .pend(inj_pend), .pend_ch(pend_ch),
    .res_data(inj_res_data), .res_chan(inj_res_chan), .upd(inj_res_upd)
  );

  always_comb begin
    st_d       = st_q;
    more_d     = more_q;
    fly_d      = fly_q;
    sched_load = 1'b0;
    sched_adv  = 1'b0;
    res_wr     = 1'b0;
    inj_take   = 1'b0;
    inj_wr     = 1'b0;
    eng_start  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cfg_start) begin
          sched_load = 1'b1;
          more_d     = 1'b1;
          st_d       = ST_NEXT;
        end
      end
      ST_NEXT: begin
        eng_start = 1'b1;
        inj_take  = inj_pend;
        fly_d     = inj_pend;
        st_d      = ST_CONV;
      end
      ST_CONV: begin
        if (eng_done) begin
          if (fly_q) begin
            inj_wr = 1'b1;
            more_d = cont_live || (scan && !pass_end);
          end else begin
            res_wr    = 1'b1;
            sched_adv = 1'b1;
            more_d    = cont_live || !wrap_now;
          end
          if (!fly_q && res_park) st_d = ST_HOLD;
          else if (more_d)        st_d = ST_NEXT;
          else                    st_d = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (res_rd) st_d = more_q ? ST_NEXT : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      more_q <= 1'b0;
      fly_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      more_q <= more_d;
      fly_q  <= fly_d;
    end
  end

  assign busy     = !idle;
  assign eng_chan = inj_pend ? pend_ch : cur_ch;

  // R1: requests to the engine are single-cycle pulses
  a_r1_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R6: no engine request while a result is held
  a_r6_no_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    res_parked |-> !eng_start);

  // R10: a sequence only ends on a completion or a read
  a_r10_end_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(eng_done || res_rd));

  // R11: nothing is requested while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_start);
endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int LAT = 3;

  logic       clk, rst_n;
  logic [1:0] cfg_mode;
  logic [3:0] cfg_chan, inj_chan, res_chan, inj_res_chan, eng_chan;
  logic       cfg_start, cfg_wait_en, busy, res_rd, res_valid, irq_ovr;
  logic       inj_req, inj_res_upd, eng_start, eng_done;
  logic [9:0] res_data, inj_res_data, eng_data;
  logic       rd_auto, rd_man, auto_rd, watch9;

  int n_chk, n_fail, start_cnt, irq_cnt, upd_cnt, bad_main, cycles;
  int start_log [0:63];

  assign res_rd = rd_auto | rd_man;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
    .cfg_start(cfg_start), .cfg_wait_en(cfg_wait_en), .busy(busy),
    .res_rd(res_rd), .res_data(res_data), .res_chan(res_chan),
    .res_valid(res_valid), .irq_ovr(irq_ovr), .inj_req(inj_req),
    .inj_chan(inj_chan), .inj_res_data(inj_res_data),
    .inj_res_chan(inj_res_chan), .inj_res_upd(inj_res_upd),
    .eng_start(eng_start), .eng_chan(eng_chan), .eng_done(eng_done),
    .eng_data(eng_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // engine model: data = channel*64 + request index
  initial begin
    eng_done = 1'b0;
    eng_data = '0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (eng_start) begin
        automatic int idx = start_cnt;
        automatic int ch  = int'(eng_chan);
        if (start_cnt < 64) start_log[start_cnt] = ch;
        start_cnt++;
        repeat (LAT) @(negedge clk);
        eng_done = 1'b1;
        eng_data = 10'(ch * 64 + (idx % 64));
      end
    end
  end

  initial begin
    rd_auto = 1'b0;
    forever begin
      @(negedge clk);
      if (auto_rd && res_valid && !rd_auto) begin
        rd_auto = 1'b1;
        if (watch9 && res_chan == 4'd9) bad_main++;
      end else rd_auto = 1'b0;
    end
  end

  initial begin
    cycles = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (irq_ovr) irq_cnt++;
      if (inj_res_upd) upd_cnt++;
      if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic go(input logic [1:0] m, input int ch, input logic w);
    @(negedge clk);
    cfg_mode = m; cfg_chan = 4'(ch); cfg_wait_en = w; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic rd_once();
    @(negedge clk); rd_man = 1'b1;
    @(negedge clk); rd_man = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
    chk(!busy, req, int'(busy), 0);
  endtask

  task automatic wait_starts(input int n);
    int t = 0;
    while (start_cnt < n && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic clear_log();
    start_cnt = 0; irq_cnt = 0; upd_cnt = 0; bad_main = 0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; start_cnt = 0; irq_cnt = 0; upd_cnt = 0; bad_main = 0;
    rst_n = 1'b0; cfg_mode = 2'b00; cfg_chan = '0; cfg_start = 1'b0;
    cfg_wait_en = 1'b0; rd_man = 1'b0; auto_rd = 1'b0; watch9 = 1'b0;
    inj_req = 1'b0; inj_chan = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !res_valid && !irq_ovr && !eng_start && !inj_res_upd,
        "R11 reset outputs", int'(busy) + int'(res_valid) + int'(eng_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !res_valid && !eng_start, "R11 after release",
        int'(busy) + int'(res_valid), 0);

    // R2 / R7: single-once sweep over every channel
    for (int ch = 0; ch < 16; ch++) begin
      clear_log();
      go(2'b00, ch, 1'b0);
      wait_idle("R2 busy falls");
      chk(start_cnt == 1, "R2 one request", start_cnt, 1);
      chk(res_valid && res_chan == 4'(ch), "R2 channel", int'(res_chan), ch);
      chk(res_data == 10'(ch * 64), "R2 data", int'(res_data), ch * 64);
      rd_once();
      chk(!res_valid, "R7 read clears valid", int'(res_valid), 0);
    end

    // R3 / R5: scan-once sweep, never read, every later result overruns
    for (int s = 0; s < 16; s++) begin
      clear_log();
      go(2'b10, s, 1'b0);
      wait_idle("R3 scan ends");
      chk(start_cnt == s + 1, "R3 request count", start_cnt, s + 1);
      for (int i = 0; i <= s; i++)
        chk(start_log[i] == s - i, "R3 descending order", start_log[i], s - i);
      chk(irq_cnt == s, "R5 overrun pulses", irq_cnt, s);
      chk(res_chan == 4'd0 && res_data == 10'(s), "R5 last result kept",
          int'(res_data), s);
      rd_once();
    end

    // R4 / R1 / R10: single-continuous, with a start ignored while busy
    clear_log();
    auto_rd = 1'b1;
    go(2'b01, 5, 1'b0);
    wait_starts(2);
    go(2'b01, 11, 1'b0);
    wait_starts(4);
    begin
      automatic int at_clr;
      @(negedge clk);
      cfg_mode = 2'b00;
      at_clr = start_cnt;
      wait_idle("R10 single stop");
      chk(start_cnt <= at_clr + 1, "R10 at most one more", start_cnt, at_clr + 1);
    end
    for (int i = 0; i < start_cnt && i < 64; i++)
      chk(start_log[i] == 5, "R4/R1 same channel", start_log[i], 5);
    chk(irq_cnt == 0, "R5 no overrun when read", irq_cnt, 0);
    @(negedge clk);
    auto_rd = 1'b0;

    // R6: hold on unread result in scan-continuous
    clear_log();
    go(2'b11, 2, 1'b1);
    wait_starts(2);
    repeat (30) @(negedge clk);
    chk(start_cnt == 2, "R6 no request while held", start_cnt, 2);
    chk(busy && res_chan == 4'd2 && res_data == 10'd128, "R6 first result kept",
        int'(res_data), 128);
    rd_once();
    chk(res_valid && res_chan == 4'd1 && res_data == 10'd65, "R6 held moved in",
        int'(res_data), 65);
    auto_rd = 1'b1;
    wait_starts(5);
    @(negedge clk);
    cfg_mode = 2'b10;
    wait_idle("R10 scan stop");
    for (int i = 0; i < 5; i++)
      chk(start_log[i] == 2 - (i % 3), "R6/R3 resumed order", start_log[i], 2 - (i % 3));
    chk(start_log[start_cnt - 1] == 0, "R10 pass ends at 0", start_log[start_cnt - 1], 0);
    chk(irq_cnt == 0, "R6 no overrun with wait", irq_cnt, 0);

    // R8: injection during scan-continuous
    @(negedge clk);
    clear_log();
    watch9 = 1'b1;
    go(2'b11, 3, 1'b0);
    wait_starts(2);
    @(negedge clk);
    inj_chan = 4'd9; inj_req = 1'b1;
    @(negedge clk);
    inj_req = 1'b0;
    wait_starts(6);
    @(negedge clk);
    cfg_mode = 2'b10;
    wait_idle("R8 stop");
    begin
      automatic int exp_seq [0:5] = '{3, 2, 9, 1, 0, 3};
      for (int i = 0; i < 6; i++)
        chk(start_log[i] == exp_seq[i], "R8 injection order", start_log[i], exp_seq[i]);
    end
    chk(inj_res_chan == 4'd9, "R8 injection channel", int'(inj_res_chan), 9);
    chk(inj_res_data == 10'd578, "R8 injection data", int'(inj_res_data), 578);
    chk(upd_cnt == 1, "R8 one update pulse", upd_cnt, 1);
    chk(bad_main == 0, "R8 not in main register", bad_main, 0);
    repeat (3) @(negedge clk);
    auto_rd = 1'b0; watch9 = 1'b0;
    if (res_valid) rd_once();

    // R9: injection ignored in a once mode
    clear_log();
    go(2'b00, 4, 1'b0);
    inj_chan = 4'd7; inj_req = 1'b1;
    @(negedge clk);
    inj_req = 1'b0;
    wait_idle("R9 once run");
    repeat (10) @(negedge clk);
    chk(start_cnt == 1, "R9 no extra request", start_cnt, 1);
    chk(upd_cnt == 0, "R9 no injection result", upd_cnt, 0);
    chk(res_chan == 4'd4, "R9 main result", int'(res_chan), 4);

    // R9: injection ignored while idle
    clear_log();
    inj_chan = 4'd6; inj_req = 1'b1;
    @(negedge clk);
    inj_req = 1'b0;
    repeat (10) @(negedge clk);
    chk(start_cnt == 0 && !busy, "R9 idle ignores", start_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule